// File: doc/BRIEF.md
# Programmable Device Bus Cycle Timer

This block turns single host requests into strobe sequences for a slow external peripheral that has an 8- or 16-bit data bus. It runs two kinds of access. A programmed I/O cycle carries an address and a direction from the host. A DMA handshake cycle is started by the peripheral's request line while the host keeps a DMA transfer enabled. Each access runs through three phases in order. The length of each phase in clocks comes from a field of a static configuration word. There is one word for programmed I/O and one for DMA.

During the three phases the peripheral sees a select line: chip select for programmed I/O, or acknowledge for DMA. The read or write strobe is raised only in the middle phase. Each configuration word also picks the bus width, byte swapping and the parity check. The DMA word additionally sets the polarity of the request line. One clock after the last phase, the host gets a one-clock completion pulse, along with the read data captured at the end of the middle phase. A parity mismatch on device data latches an error flag and raises an interrupt until the host clears it.

Top module: `dev_cycle_timer`

## Requirements
- R1: A programmed I/O cycle holds chip select through phase 1, then phase 2, then phase 3. The lengths in clocks come from the I/O configuration word: phase 1 from bits 11:9, phase 3 from bits 1:0, and phase 2 from bits 8:5 on a read or from bits 4:2 on a write.
- R2: A phase field of value zero gives a one-clock phase, so every phase lasts at least one clock.
- R3: The select line stays high for all three phases. The read strobe (reads) or write strobe (writes) is high only for the clocks of phase 2, and never both at once. On write cycles, the device data output enable is high for the whole cycle. The latched address is presented on the device address bus.
- R4: A completion pulse, exactly one clock wide, appears in the clock after phase 3 ends. For reads, host read data holds the device data sampled in the last clock of phase 2.
- R5: Bit 12 of the active configuration word selects 16-bit transfers. When it is clear, only the low byte lane is used: written data drives zeros in the upper lane, and read data returns zeros in its upper byte.
- R6: Bit 13 of the active configuration word exchanges the two byte lanes in both directions during 16-bit transfers. In 8-bit mode it has no effect.
- R7: Every driven data byte carries an odd parity bit on the device parity output. When bit 14 of the active configuration word is set, a read whose device parity does not make any active byte lane odd sets a sticky parity error flag and the interrupt. The flag and interrupt stay set until the clear input is pulsed.
- R8: A DMA cycle holds the acknowledge line (never chip select) through three phases. The lengths come from bits 2:1, 5:3 and 8:6 of the DMA configuration word. The read strobe (transfer toward the host) or write strobe is raised in the middle phase, and a DMA completion pulse follows.
- R9: Bit 15 of the DMA configuration word selects the request polarity: 0 means the request line is active high, 1 means it is active low. An inactive request starts no DMA cycle.
- R10: While DMA is enabled and the active-mask input is high, no programmed I/O cycle starts; it starts once DMA is disabled. With the mask low, a pending I/O request proceeds while DMA is enabled but not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pio_cfg | input | 16 | Programmed I/O timing and option word |
| dma_cfg | input | 16 | DMA timing and option word |
| pio_req | input | 1 | Programmed I/O request, held until pio_done |
| pio_wr | input | 1 | 1 = write, 0 = read |
| pio_addr | input | ADDR_W | Device register address |
| pio_wdata | input | DATA_W | Write data for I/O cycles |
| dma_en | input | 1 | DMA transfer enabled by the host |
| dma_amask | input | 1 | Active DMA blocks programmed I/O |
| dma_to_host | input | 1 | DMA direction, 1 = device to host |
| dma_wdata | input | DATA_W | Write data for DMA cycles |
| irq_clr | input | 1 | Clears parity error and interrupt |
| host_rdata | output | DATA_W | Last captured read data |
| pio_done | output | 1 | I/O cycle completion pulse |
| dma_done | output | 1 | DMA cycle completion pulse |
| par_err | output | 1 | Sticky parity error flag |
| irq | output | 1 | Interrupt request |
| dev_cs | output | 1 | Device chip select for I/O cycles |
| dev_dack | output | 1 | DMA acknowledge |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_oe | output | 1 | Device data output enable |
| dev_addr | output | ADDR_W | Device address |
| dev_dout | output | DATA_W | Data to the device |
| dev_pout | output | LANES | Odd parity per driven byte lane |
| dev_din | input | DATA_W | Data from the device |
| dev_pin | input | LANES | Parity from the device per byte lane |
| dev_dreq | input | 1 | Device DMA request |

## Verification
The I/O cycle is tried with reads and writes whose three fields are all distinct. This separates the read-length field from the write-length field and catches any swapped phase fields. An all-zero configuration and an all-maximum configuration pin down the one-clock floor and the widest counts. Data patterns with unequal bytes are run through 8-bit, 16-bit, swapped and unswapped modes, so a lane exchange or a dropped upper byte shows up in the returned value. DMA, request polarity, the active-mask hold-off and parity errors on only the upper lane are then driven one at a time. The upper-lane errors show whether the check respects the bus width.

// File: rtl/dcyc_pkg.sv
package dcyc_pkg;

   localparam int CNT_W = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_1,
      PH_2,
      PH_3,
      PH_DONE
   } phase_t;

   // option bits shared by both configuration words
   localparam int OPT_HALF = 12;
   localparam int OPT_SWAP = 13;
   localparam int OPT_PCHK = 14;
   localparam int DQ_POL   = 15;

   // a zero field still gives one clock
   function automatic logic [CNT_W-1:0] ph_len(input logic [CNT_W-1:0] f);
      return (f == '0) ? CNT_W'(1) : f;
   endfunction

endpackage

// File: rtl/dcyc_phase_seq.sv
module dcyc_phase_seq
   import dcyc_pkg::*;
#(
   parameter int LEN_W = CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len1,
   input  logic [LEN_W-1:0] len2,
   input  logic [LEN_W-1:0] len3,
   output phase_t           phase,
   output logic             ph_last
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_1;
               cnt_q <= len1 - 1'b1;
            end
            PH_1: if (cnt_q == '0) begin
               phase <= PH_2;
               cnt_q <= len2 - 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
            PH_2: if (cnt_q == '0) begin
               phase <= PH_3;
               cnt_q <= len3 - 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
            PH_3: if (cnt_q == '0) phase <= PH_DONE;
                  else cnt_q <= cnt_q - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign ph_last = (cnt_q == '0);

   // R2: lengths handed to the sequencer are never zero
   p_len_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start) |-> (len1 != '0));
   // R1: phase 1 either continues or moves to phase 2
   p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_1) |=> (phase == PH_1 || phase == PH_2));
   p_mid_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_2) |=> (phase == PH_2 || phase == PH_3));
   // R4: completion lasts one clock
   p_done_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE));

endmodule

// File: rtl/dcyc_lane_path.sv
module dcyc_lane_path #(
   parameter int LANES  = 2,
   localparam int DATA_W = 8 * LANES
) (
   input  logic              half,
   input  logic              swap,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] din,
   input  logic [LANES-1:0]  pin,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  pout,
   output logic [DATA_W-1:0] rval,
   output logic              par_bad
);

   logic [DATA_W-1:0] wrev, rrev;
   logic [LANES-1:0]  bad;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wrev[8*g +: 8] = wdata[8*(LANES-1-g) +: 8];
      assign rrev[8*g +: 8] = din[8*(LANES-1-g) +: 8];
      assign pout[g]        = ~^dout[8*g +: 8];
      if (g == 0) begin : g_low
         assign bad[g] = (pin[g] != ~^din[8*g +: 8]);
      end else begin : g_high
         assign bad[g] = half & (pin[g] != ~^din[8*g +: 8]);
      end
   end

   always_comb begin
      if (half) begin
         dout = swap ? wrev : wdata;
         rval = swap ? rrev : din;
      end else begin
         dout = {{(DATA_W-8){1'b0}}, wdata[7:0]};
         rval = {{(DATA_W-8){1'b0}}, din[7:0]};
      end
   end

   assign par_bad = |bad;

endmodule

// File: rtl/dev_cycle_timer.sv
module dev_cycle_timer
   import dcyc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   localparam int DATA_W = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       pio_cfg,
   input  logic [15:0]       dma_cfg,
   input  logic              pio_req,
   input  logic              pio_wr,
   input  logic [ADDR_W-1:0] pio_addr,
   input  logic [DATA_W-1:0] pio_wdata,
   input  logic              dma_en,
   input  logic              dma_amask,
   input  logic              dma_to_host,
   input  logic [DATA_W-1:0] dma_wdata,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] host_rdata,
   output logic              pio_done,
   output logic              dma_done,
   output logic              par_err,
   output logic              irq,
   output logic              dev_cs,
   output logic              dev_dack,
   output logic              dev_rd,
   output logic              dev_wr,
   output logic              dev_oe,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_dout,
   output logic [LANES-1:0]  dev_pout,
   input  logic [DATA_W-1:0] dev_din,
   input  logic [LANES-1:0]  dev_pin,
   input  logic              dev_dreq
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("dev_cycle_timer: ADDR_W must be at least 1");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("dev_cycle_timer: LANES must be at least 2");
   end

   phase_t            phase;
   logic              ph_last;
   logic              kind_q, wr_q, perr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, rval;
   logic [CNT_W-1:0]  l1, l2, l3;
   logic              idle, dreq_act, dma_go, pio_go, start;
   logic              kind_eff, wr_eff, busy, capture, par_bad;
   logic              opt_half, opt_swap, opt_pchk;
   logic              cfg_unused;

   assign cfg_unused = ^{pio_cfg[15], dma_cfg[11:9], dma_cfg[0]};

   assign idle     = (phase == PH_IDLE);
   assign dreq_act = dev_dreq ^ dma_cfg[DQ_POL];
   assign dma_go   = idle & dma_en & dreq_act;
   assign pio_go   = idle & pio_req & ~dma_go & ~(dma_en & dma_amask);
   assign start    = dma_go | pio_go;
   assign kind_eff = idle ? dma_go : kind_q;
   assign wr_eff   = idle ? (dma_go ? ~dma_to_host : pio_wr) : wr_q;

   always_comb begin
      if (kind_eff) begin
         l1 = ph_len({2'b00, dma_cfg[2:1]});
         l2 = ph_len({1'b0, dma_cfg[5:3]});
         l3 = ph_len({1'b0, dma_cfg[8:6]});
      end else begin
         l1 = ph_len({1'b0, pio_cfg[11:9]});
         l2 = wr_eff ? ph_len({1'b0, pio_cfg[4:2]}) : ph_len(pio_cfg[8:5]);
         l3 = ph_len({2'b00, pio_cfg[1:0]});
      end
   end

   dcyc_phase_seq #(.LEN_W(CNT_W)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .len1   (l1),
      .len2   (l2),
      .len3   (l3),
      .phase  (phase),
      .ph_last(ph_last)
   );

   assign opt_half = kind_q ? dma_cfg[OPT_HALF] : pio_cfg[OPT_HALF];
   assign opt_swap = kind_q ? dma_cfg[OPT_SWAP] : pio_cfg[OPT_SWAP];
   assign opt_pchk = kind_q ? dma_cfg[OPT_PCHK] : pio_cfg[OPT_PCHK];

   dcyc_lane_path #(.LANES(LANES)) i_lanes (
      .half   (opt_half),
      .swap   (opt_swap),
      .wdata  (wdata_q),
      .din    (dev_din),
      .pin    (dev_pin),
      .dout   (dev_dout),
      .pout   (dev_pout),
      .rval   (rval),
      .par_bad(par_bad)
   );

   assign capture = (phase == PH_2) & ph_last & ~wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         perr_q  <= 1'b0;
      end else begin
         if (start) begin
            kind_q  <= dma_go;
            wr_q    <= wr_eff;
            wdata_q <= dma_go ? dma_wdata : pio_wdata;
         end
         if (pio_go) addr_q <= pio_addr;
         if (capture) rdata_q <= rval;
         if (irq_clr) perr_q <= 1'b0;
         if (capture && opt_pchk && par_bad) perr_q <= 1'b1;
      end
   end

   assign busy       = (phase == PH_1) | (phase == PH_2) | (phase == PH_3);
   assign dev_cs     = busy & ~kind_q;
   assign dev_dack   = busy & kind_q;
   assign dev_rd     = (phase == PH_2) & ~wr_q;
   assign dev_wr     = (phase == PH_2) & wr_q;
   assign dev_oe     = busy & wr_q;
   assign dev_addr   = addr_q;
   assign host_rdata = rdata_q;
   assign pio_done   = (phase == PH_DONE) & ~kind_q;
   assign dma_done   = (phase == PH_DONE) & kind_q;
   assign par_err    = perr_q;
   assign irq        = perr_q;

   // R3: strobes only inside a selected cycle, never together
   p_strobe_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd || dev_wr) |-> (dev_cs || dev_dack));
   p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr));
   // R8: chip select and acknowledge never overlap
   p_sel_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_cs && dev_dack));
   // R4: completion pulses are one clock wide
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_done || dma_done) |=> !(pio_done || dma_done));
   // R7: the error flag holds until cleared
   p_perr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !irq_clr) |=> par_err);
   // R10: masked DMA keeps programmed I/O from starting
   p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && dma_en && dma_amask) |=> !dev_cs);

endmodule

// File: tb/test_dev_cycle_timer.sv
`timescale 1ns/1ps
module test_dev_cycle_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pio_cfg = '0, dma_cfg = '0;
   logic        pio_req = 0, pio_wr = 0, dma_en = 0, dma_amask = 0;
   logic        dma_to_host = 0, irq_clr = 0, dev_dreq = 0;
   logic [7:0]  pio_addr = '0;
   logic [15:0] pio_wdata = '0, dma_wdata = '0, dev_din = '0;
   logic [1:0]  dev_pin = '0;
   logic [15:0] host_rdata, dev_dout;
   logic [7:0]  dev_addr;
   logic [1:0]  dev_pout;
   logic        pio_done, dma_done, par_err, irq;
   logic        dev_cs, dev_dack, dev_rd, dev_wr, dev_oe;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dev_cycle_timer #(.ADDR_W(8), .LANES(2)) i_dev_cycle_timer (
      .clk, .rst_n, .pio_cfg, .dma_cfg, .pio_req, .pio_wr, .pio_addr,
      .pio_wdata, .dma_en, .dma_amask, .dma_to_host, .dma_wdata, .irq_clr,
      .host_rdata, .pio_done, .dma_done, .par_err, .irq, .dev_cs, .dev_dack,
      .dev_rd, .dev_wr, .dev_oe, .dev_addr, .dev_dout, .dev_pout, .dev_din,
      .dev_pin, .dev_dreq
   );

   typedef struct packed {
      logic        wr;
      logic        hw;
      logic        sw;
      logic [2:0]  p1;
      logic [3:0]  p2r;
      logic [2:0]  p2w;
      logic [1:0]  p3;
      logic [15:0] wdat;
      logic [15:0] din;
      logic [15:0] expd;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b1, 1'b0, 3'd2, 4'd5,  3'd1, 2'd1, 16'h0000, 16'hA53C, 16'hA53C},
      '{1'b1, 1'b1, 1'b0, 3'd3, 4'd9,  3'd4, 2'd2, 16'h1234, 16'h0000, 16'h1234},
      '{1'b0, 1'b1, 1'b0, 3'd0, 4'd0,  3'd0, 2'd0, 16'h0000, 16'hBEEF, 16'hBEEF},
      '{1'b0, 1'b1, 1'b1, 3'd7, 4'd15, 3'd2, 2'd3, 16'h0000, 16'h12AB, 16'hAB12},
      '{1'b1, 1'b1, 1'b1, 3'd1, 4'd3,  3'd7, 2'd0, 16'hCAFE, 16'h0000, 16'hFECA},
      '{1'b0, 1'b0, 1'b0, 3'd1, 4'd2,  3'd6, 2'd1, 16'h0000, 16'h77C4, 16'h00C4},
      '{1'b1, 1'b0, 1'b1, 3'd2, 4'd1,  3'd3, 2'd2, 16'h5A69, 16'h0000, 16'h0069},
      '{1'b0, 1'b0, 1'b1, 3'd1, 4'd4,  3'd1, 2'd1, 16'h0000, 16'h3396, 16'h0096}
   };

   function automatic int plen(input int f);
      return (f == 0) ? 1 : f;
   endfunction

   function automatic logic [1:0] par2(input logic [15:0] d);
      return {~^d[15:8], ~^d[7:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // counts observed strobes until a completion pulse, then drops requests
   int  c_sel, c_dk, c_rd, c_wr, c_oe;
   bit  c_done;
   logic [15:0] s_dout;
   logic [1:0]  s_pout;
   logic [7:0]  s_addr;

   task automatic run_xfer();
      c_sel = 0; c_dk = 0; c_rd = 0; c_wr = 0; c_oe = 0; c_done = 0;
      for (int k = 0; k < 100 && !c_done; k++) begin
         @(negedge clk);
         if (dev_cs)   c_sel++;
         if (dev_dack) c_dk++;
         if (dev_rd)   c_rd++;
         if (dev_oe)   c_oe++;
         if (dev_wr) begin
            c_wr++;
            s_dout = dev_dout;
            s_pout = dev_pout;
         end
         if (dev_rd || dev_wr) s_addr = dev_addr;
         if (pio_done || dma_done) begin
            c_done  = 1;
            pio_req = 0;
            dma_en  = 0;
         end
      end
      check("R4 completion seen", c_done, 1);
      @(negedge clk);
      check("R4 pulse one clock", pio_done | dma_done, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      int   mid, tot;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R3, R4, R7)
      check("R3 reset selects", {dev_cs, dev_dack, dev_rd, dev_wr, dev_oe}, 0);
      check("R4 reset done/data", {pio_done, dma_done, host_rdata}, 0);
      check("R7 reset irq", {par_err, irq}, 0);

      // table walk: R1 R2 R3 R5 R6 R7
      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         pio_cfg   = {1'b0, 1'b0, v.sw, v.hw, v.p1, v.p2r, v.p2w, v.p3};
         pio_wr    = v.wr;
         pio_wdata = v.wdat;
         pio_addr  = 8'(i + 16);
         dev_din   = v.din;
         dev_pin   = par2(v.din);
         pio_req   = 1;
         run_xfer();
         mid = v.wr ? plen(int'(v.p2w)) : plen(int'(v.p2r));
         tot = plen(int'(v.p1)) + mid + plen(int'(v.p3));
         check((i == 2) ? "R2 zero fields length" : "R1 phase total", c_sel, tot);
         check("R3 strobe in phase 2", v.wr ? c_wr : c_rd, mid);
         check("R3 opposite strobe idle", v.wr ? c_rd : c_wr, 0);
         check("R3 output enable", c_oe, v.wr ? tot : 0);
         check("R3 address", s_addr, 8'(i + 16));
         check("R8 no acknowledge on I/O", c_dk, 0);
         if (v.wr) begin
            check("R5 R6 write data", s_dout, v.expd);
            check("R7 parity out", s_pout, par2(v.expd));
         end else begin
            check("R5 R6 read data", host_rdata, v.expd);
         end
      end

      // R7: parity error on the upper lane in 16-bit mode
      pio_cfg = {1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 4'd2, 3'd1, 2'd1};
      pio_wr  = 0;
      dev_din = 16'h0103;
      dev_pin = par2(16'h0103);
      pio_req = 1;
      run_xfer();
      check("R7 good parity no error", irq, 0);
      dev_pin = par2(16'h0103) ^ 2'b10;
      pio_req = 1;
      run_xfer();
      check("R7 bad parity sets irq", {par_err, irq}, 2'b11);
      dev_pin = par2(16'h0103);
      pio_req = 1;
      run_xfer();
      check("R7 error is sticky", par_err, 1);
      irq_clr = 1;
      @(negedge clk);
      irq_clr = 0;
      check("R7 clear drops irq", {par_err, irq}, 0);
      // R7 with R5: upper-lane error ignored in 8-bit mode
      pio_cfg[12] = 1'b0;
      dev_pin = par2(16'h0103) ^ 2'b10;
      pio_req = 1;
      run_xfer();
      check("R7 R5 upper lane unchecked in byte mode", par_err, 0);

      // R8: DMA read toward host, 16-bit swapped
      dma_cfg     = {1'b0, 1'b0, 1'b1, 1'b1, 3'b000, 3'd1, 3'd3, 2'd2, 1'b0};
      dma_to_host = 1;
      dev_din     = 16'h4321;
      dev_dreq    = 1;
      dma_en      = 1;
      run_xfer();
      check("R8 acknowledge length", c_dk, 6);
      check("R8 read strobe in middle", c_rd, 3);
      check("R8 no chip select", c_sel, 0);
      check("R8 DMA data", host_rdata, 16'h2143);
      // R8 with R2: DMA write, zero fields, 8-bit
      dma_cfg     = '0;
      dma_to_host = 0;
      dma_wdata   = 16'hA5F0;
      dma_en      = 1;
      run_xfer();
      check("R8 R2 minimal DMA length", c_dk, 3);
      check("R8 write strobe", c_wr, 1);
      check("R8 R5 DMA byte write", s_dout, 16'h00F0);

      // R9: active-low request
      dma_cfg  = {1'b1, 15'h0};
      dev_dreq = 1;
      dma_en   = 1;
      c_dk = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (dev_dack) c_dk++;
      end
      check("R9 inactive request ignored", c_dk, 0);
      dev_dreq = 0;
      run_xfer();
      check("R9 low request starts DMA", c_dk, 3);

      // R10: masked hold-off, then release
      dev_dreq  = 1;
      dma_en    = 1;
      dma_amask = 1;
      pio_cfg   = {4'b0000, 3'd1, 4'd1, 3'd1, 2'd1};
      pio_wr    = 1;
      pio_req   = 1;
      c_sel = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (dev_cs || dev_dack) c_sel++;
      end
      check("R10 I/O held off", c_sel, 0);
      dma_en = 0;
      run_xfer();
      check("R10 I/O runs after DMA", c_sel, 3);
      // R10: without mask the request proceeds at once
      dma_amask = 0;
      dma_en    = 1;
      pio_req   = 1;
      run_xfer();
      check("R10 unmasked I/O proceeds", c_sel, 3);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule